// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out where an instruction's operand lives for an 8-bit processor with a 16-bit address space. The instruction sequencer pulses `start` with the addressing-mode code, the address of the opcode byte and the two index registers. The unit then walks through the operand bytes and, where the mode needs it, a two-byte pointer, using a byte-wide read port. When it is done it presents the effective address, the instruction length in bytes and a flag saying the operand is the accumulator, together with a one-cycle `valid` pulse.

The read port is asynchronous: while `mem_rd` is high, `mem_data` must carry the byte at `mem_addr` in the same cycle. Each byte therefore costs one clock. The mode code, program counter and index values are captured when a request is accepted, so the sequencer may change them freely while the unit is busy.

Top module: `ea_gen`

## Requirements
- R1: The length is 1 for accumulator (code 0), implied (code 5) and the unused codes 13 to 15. It is 3 for absolute (1), absolute+X (2), absolute+Y (3) and indirect (6). It is 2 for immediate (4), indexed-indirect (7), indirect-indexed (8), relative (9), zero page (10), zero page+X (11) and zero page+Y (12).
- R2: `acc_tgt` is 1 only for mode 0. Modes 0 and 5 and codes 13 to 15 give address 0 and make no memory reads.
- R3: Immediate mode gives pc+1 modulo 65536 and makes no memory read. `valid` is high in the first cycle after the accepting clock edge.
- R4: The absolute modes take the low address byte from pc+1 and the high byte from pc+2. Absolute+X adds X and absolute+Y adds Y, with the sum taken modulo 65536.
- R5: The zero-page modes use the byte at pc+1, plus X for mode 11 or plus Y for mode 12, wrapped to 8 bits. The upper address byte is always 0.
- R6: Relative mode gives pc plus the byte at pc+1 read as a signed two's-complement value, modulo 65536.
- R7: Indexed-indirect forms z = (byte at pc+1 + X) mod 256. It reads the pointer low byte at z and the high byte at (z+1) mod 256, and the pointer is the result.
- R8: Indirect-indexed reads the pointer low byte at zero-page address b (the byte at pc+1) and the high byte at (b+1) mod 256. It then adds Y modulo 65536.
- R9: Indirect mode reads the pointer low byte at the absolute address a given by the operand and the high byte at a+1 (16-bit increment). The pointer is the result.
- R10: A request is taken when `start` is high and `busy` is low. Memory reads take one cycle each. The read counts are 0 for modes 0, 4, 5 and 13 to 15; 1 for modes 9 to 12; 2 for modes 1 to 3; 3 for modes 7 and 8; and 4 for mode 6. `valid` is a single-cycle pulse that arrives reads+1 cycles after the accepting edge, with `busy` and `mem_rd` low.
- R11: While `busy` is high, `start` and changes to `mode`, `pc`, `idx_x` and `idx_y` have no effect on the result, and they produce no extra `valid`.
- R12: After reset, `valid`, `busy` and `mem_rd` are 0 and `ea`, `len` and `acc_tgt` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when idle |
| mode | input | 4 | Addressing-mode code |
| pc | input | 16 | Address of the opcode byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_data | input | 8 | Read data, valid in the cycle of the request |
| busy | output | 1 | A request is in progress |
| valid | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address |
| len | output | 2 | Instruction length in bytes |
| acc_tgt | output | 1 | Operand is the accumulator |

## Verification
The bench aims at the wrap boundaries.

- A zero-page index that crosses 0xFF must stay in page 0. A design that carried into the upper byte would return 0x01xx.
- The high byte of a zero-page pointer taken at 0xFF must come from 0x00. A design that incremented on 16 bits would read 0x0100 and build a different pointer.
- An absolute-indexed sum, an indirect-indexed sum and a forward branch near the top of memory must all wrap through 0xFFFF.
- A negative relative offset must subtract. A design missing sign extension would land 256 bytes too high.

Read counts and latency are measured per mode, so a wrong fetch sequence shows up even when the address happens to match. A second request and changed inputs applied during a long indirect fetch check that the captured operands are the ones used.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    AM_ACC  = 4'd0,
    AM_ABS  = 4'd1,
    AM_ABSX = 4'd2,
    AM_ABSY = 4'd3,
    AM_IMM  = 4'd4,
    AM_IMPL = 4'd5,
    AM_IND  = 4'd6,
    AM_XIND = 4'd7,
    AM_INDY = 4'd8,
    AM_REL  = 4'd9,
    AM_ZP   = 4'd10,
    AM_ZPX  = 4'd11,
    AM_ZPY  = 4'd12
  } am_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OP_LO,
    ST_OP_HI,
    ST_PT_LO,
    ST_PT_HI
  } st_e;
endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
#(
  parameter int LEN_W = 2
) (
  input  logic [3:0]       mode,
  output logic [LEN_W-1:0] len,
  output logic             acc,
  output logic             fetch,
  output logic             wide_op,
  output logic             via_ptr,
  output logic             zp_ptr
);
  always_comb begin
    len     = LEN_W'(1);
    acc     = 1'b0;
    fetch   = 1'b0;
    wide_op = 1'b0;
    via_ptr = 1'b0;
    zp_ptr  = 1'b0;
    case (mode)
      AM_ACC: acc = 1'b1;
      AM_IMM: len = LEN_W'(2);
      AM_ABS, AM_ABSX, AM_ABSY: begin
        len = LEN_W'(3); fetch = 1'b1; wide_op = 1'b1;
      end
      AM_IND: begin
        len = LEN_W'(3); fetch = 1'b1; wide_op = 1'b1; via_ptr = 1'b1;
      end
      AM_XIND, AM_INDY: begin
        len = LEN_W'(2); fetch = 1'b1; via_ptr = 1'b1; zp_ptr = 1'b1;
      end
      AM_REL, AM_ZP, AM_ZPX, AM_ZPY: begin
        len = LEN_W'(2); fetch = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_addr_math.sv
module ea_addr_math
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic [3:0]    mode,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] ix,
  input  logic [DW-1:0] iy,
  input  logic [DW-1:0] byte_in,
  input  logic [DW-1:0] lo,
  output logic [DW-1:0] zp_sum,
  output logic [AW-1:0] rel_tgt,
  output logic [AW-1:0] word,
  output logic [AW-1:0] word_sum
);
  logic [DW-1:0] pre_idx, post_idx;

  always_comb begin
    case (mode)
      AM_ZPX, AM_XIND: pre_idx = ix;
      AM_ZPY:          pre_idx = iy;
      default:         pre_idx = '0;
    endcase
    case (mode)
      AM_ABSX:          post_idx = ix;
      AM_ABSY, AM_INDY: post_idx = iy;
      default:          post_idx = '0;
    endcase
  end

  assign zp_sum   = byte_in + pre_idx;
  assign rel_tgt  = pc + {{DW{byte_in[DW-1]}}, byte_in};
  assign word     = {byte_in, lo};
  assign word_sum = word + {{DW{1'b0}}, post_idx};
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int DW = 8,
  parameter int MODE_W = 4,
  parameter int LEN_W = 2,
  localparam int AW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     pc,
  input  logic [DW-1:0]     idx_x,
  input  logic [DW-1:0]     idx_y,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [DW-1:0]     mem_data,
  output logic              busy,
  output logic              valid,
  output logic [AW-1:0]     ea,
  output logic [LEN_W-1:0]  len,
  output logic              acc_tgt
);
  st_e               state;
  logic [MODE_W-1:0] mode_q;
  logic [AW-1:0]     pc_q, addr_q, ea_q;
  logic [DW-1:0]     x_q, y_q, lo_q;
  logic              rd_q, valid_q, acc_q;
  logic [LEN_W-1:0]  len_q;

  logic [MODE_W-1:0] cur_mode;
  logic [LEN_W-1:0]  d_len;
  logic              d_acc, d_fetch, d_wide, d_ptr, d_zpp;
  logic [DW-1:0]     zp_sum;
  logic [AW-1:0]     rel_tgt, word, word_sum;

  assign cur_mode = (state == ST_IDLE) ? mode : mode_q;

  ea_mode_decode #(.LEN_W(LEN_W)) u_dec (
    .mode(cur_mode), .len(d_len), .acc(d_acc), .fetch(d_fetch),
    .wide_op(d_wide), .via_ptr(d_ptr), .zp_ptr(d_zpp)
  );

  ea_addr_math #(.DW(DW)) u_math (
    .mode(mode_q), .pc(pc_q), .ix(x_q), .iy(y_q), .byte_in(mem_data),
    .lo(lo_q), .zp_sum(zp_sum), .rel_tgt(rel_tgt), .word(word),
    .word_sum(word_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mode_q  <= '0;
      pc_q    <= '0;
      x_q     <= '0;
      y_q     <= '0;
      lo_q    <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      valid_q <= 1'b0;
      ea_q    <= '0;
      len_q   <= '0;
      acc_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q <= mode;
            pc_q   <= pc;
            x_q    <= idx_x;
            y_q    <= idx_y;
            len_q  <= d_len;
            acc_q  <= d_acc;
            if (d_fetch) begin
              addr_q <= pc + AW'(1);
              rd_q   <= 1'b1;
              state  <= ST_OP_LO;
            end else begin
              ea_q    <= (mode == AM_IMM) ? pc + AW'(1) : '0;
              valid_q <= 1'b1;
            end
          end
        end
        ST_OP_LO: begin
          lo_q <= mem_data;
          if (d_wide) begin
            addr_q <= pc_q + AW'(2);
            state  <= ST_OP_HI;
          end else if (d_zpp) begin
            addr_q <= {{DW{1'b0}}, zp_sum};
            state  <= ST_PT_LO;
          end else begin
            ea_q    <= (mode_q == AM_REL) ? rel_tgt : {{DW{1'b0}}, zp_sum};
            rd_q    <= 1'b0;
            valid_q <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_OP_HI: begin
          if (d_ptr) begin
            addr_q <= word;
            state  <= ST_PT_LO;
          end else begin
            ea_q    <= word_sum;
            rd_q    <= 1'b0;
            valid_q <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        ST_PT_LO: begin
          lo_q   <= mem_data;
          addr_q <= d_zpp ? {{DW{1'b0}}, addr_q[DW-1:0] + DW'(1)}
                          : addr_q + AW'(1);
          state  <= ST_PT_HI;
        end
        ST_PT_HI: begin
          ea_q    <= word_sum;
          rd_q    <= 1'b0;
          valid_q <= 1'b1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign mem_rd   = rd_q;
  assign mem_addr = addr_q;
  assign valid    = valid_q;
  assign ea       = ea_q;
  assign len      = len_q;
  assign acc_tgt  = acc_q;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [3:0]    mode,
  input logic [AW-1:0] pc,
  input logic          busy,
  input logic          mem_rd,
  input logic          valid,
  input logic [AW-1:0] ea,
  input logic [1:0]    len,
  input logic          acc_tgt
);
  logic [3:0]    m_l;
  logic [AW-1:0] pc_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_l  <= '0;
      pc_l <= '0;
    end else if (start && !busy) begin
      m_l  <= mode;
      pc_l <= pc;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);  // R10
  AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);  // R10
  AST_IDLE_AT_VALID: assert property (@(posedge clk) disable iff (rst)
    valid |-> (!busy && !mem_rd));  // R10
  AST_ZP_PAGE: assert property (@(posedge clk) disable iff (rst)
    (valid && (m_l == AM_ZP || m_l == AM_ZPX || m_l == AM_ZPY))
      |-> (ea[AW-1:DW] == '0));  // R5
  AST_SHORT_LEN: assert property (@(posedge clk) disable iff (rst)
    (valid && (m_l == AM_ACC || m_l == AM_IMPL)) |-> (len == 2'd1));  // R1
  AST_ACC_FLAG: assert property (@(posedge clk) disable iff (rst)
    valid |-> (acc_tgt == (m_l == AM_ACC)));  // R2
  AST_IMM_ADDR: assert property (@(posedge clk) disable iff (rst)
    (valid && m_l == AM_IMM) |-> (ea == pc_l + AW'(1)));  // R3
  AST_IMM_FAST: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == AM_IMM) |=> valid);  // R3
endmodule

bind ea_gen ea_gen_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .pc(pc), .busy(busy),
  .mem_rd(mem_rd), .valid(valid), .ea(ea), .len(len), .acc_tgt(acc_tgt)
);

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pc = '0;
  logic [7:0]  idx_x = '0, idx_y = '0;
  logic        mem_rd, busy, valid, acc_tgt;
  logic [15:0] mem_addr, ea;
  logic [7:0]  mem_data;
  logic [1:0]  len;

  int checks = 0;
  int fails = 0;
  int cyc_total = 0;

  logic [15:0] ov_a [8];
  logic [7:0]  ov_d [8];
  logic        ov_v [8];

  ea_gen uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .pc(pc),
    .idx_x(idx_x), .idx_y(idx_y), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy), .valid(valid), .ea(ea), .len(len),
    .acc_tgt(acc_tgt)
  );

  always #4 clk = ~clk;

  always_comb begin
    mem_data = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'h3C;
    for (int i = 0; i < 8; i++)
      if (ov_v[i] && ov_a[i] == mem_addr) mem_data = ov_d[i];
  end

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc_total);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 8; i++) begin
      ov_v[i] = 1'b0; ov_a[i] = '0; ov_d[i] = '0;
    end
  endtask

  task automatic put(input int slot, input logic [15:0] a, input logic [7:0] d);
    ov_a[slot] = a; ov_d[slot] = d; ov_v[slot] = 1'b1;
  endtask

  // One request; measures cycles to valid and reads, then checks results.
  task automatic run(input string req, input logic [3:0] m, input logic [15:0] p,
                     input logic [7:0] x, input logic [7:0] y,
                     input logic [15:0] exp_ea, input int exp_len,
                     input int exp_acc, input int exp_reads);
    int cyc = 0;
    int rds = 0;
    logic got = 1'b0;
    @(negedge clk);
    start = 1'b1; mode = m; pc = p; idx_x = x; idx_y = y;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 40; i++) begin
      cyc++;
      if (mem_rd) rds++;
      if (valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
    check(req, "valid seen", int'(got), 1);
    check(req, "ea", int'(ea), int'(exp_ea));
    check(req, "len", int'(len), exp_len);
    check(req, "acc_tgt", int'(acc_tgt), exp_acc);
    check("R10", "reads", rds, exp_reads);
    check("R10", "latency", cyc, exp_reads + 1);
    @(negedge clk);
    check("R10", "valid one cycle", int'(valid), 0);
  endtask

  task automatic t_reset();
    check("R12", "valid", int'(valid), 0);
    check("R12", "busy", int'(busy), 0);
    check("R12", "mem_rd", int'(mem_rd), 0);
    check("R12", "ea", int'(ea), 0);
    check("R12", "len", int'(len), 0);
    check("R12", "acc_tgt", int'(acc_tgt), 0);
  endtask

  task automatic t_no_fetch();
    clear_mem();
    run("R2", 4'd0, 16'h1234, 8'h11, 8'h22, 16'h0000, 1, 1, 0);
    run("R1", 4'd5, 16'h1234, 8'h11, 8'h22, 16'h0000, 1, 0, 0);
    run("R1", 4'd14, 16'h4321, 8'h11, 8'h22, 16'h0000, 1, 0, 0);
    run("R3", 4'd4, 16'h1234, 8'h00, 8'h00, 16'h1235, 2, 0, 0);
    run("R3", 4'd4, 16'hFFFF, 8'h00, 8'h00, 16'h0000, 2, 0, 0);
  endtask

  task automatic t_absolute();
    clear_mem();
    put(0, 16'h2001, 8'h34); put(1, 16'h2002, 8'h12);
    run("R4", 4'd1, 16'h2000, 8'h55, 8'h66, 16'h1234, 3, 0, 2);
    clear_mem();
    put(0, 16'h2001, 8'hA0); put(1, 16'h2002, 8'hFF);
    run("R4", 4'd2, 16'h2000, 8'hF0, 8'h01, 16'h0090, 3, 0, 2);
    run("R4", 4'd3, 16'h2000, 8'hF0, 8'h05, 16'hFFA5, 3, 0, 2);
  endtask

  task automatic t_zero_page();
    clear_mem();
    put(0, 16'h0501, 8'h80);
    run("R5", 4'd10, 16'h0500, 8'h90, 8'h90, 16'h0080, 2, 0, 1);
    run("R5", 4'd11, 16'h0500, 8'h90, 8'h00, 16'h0010, 2, 0, 1);
    clear_mem();
    put(0, 16'h0501, 8'hFF);
    run("R5", 4'd12, 16'h0500, 8'h00, 8'h01, 16'h0000, 2, 0, 1);
  endtask

  task automatic t_relative();
    clear_mem();
    put(0, 16'h1001, 8'hFE);
    run("R6", 4'd9, 16'h1000, 8'h00, 8'h00, 16'h0FFE, 2, 0, 1);
    clear_mem();
    put(0, 16'h1001, 8'h10);
    run("R6", 4'd9, 16'h1000, 8'h00, 8'h00, 16'h1010, 2, 0, 1);
    clear_mem();
    put(0, 16'hFFF1, 8'h20);
    run("R6", 4'd9, 16'hFFF0, 8'h00, 8'h00, 16'h0010, 2, 0, 1);
  endtask

  task automatic t_indexed_indirect();
    clear_mem();
    put(0, 16'h0601, 8'hFE); put(1, 16'h00FF, 8'h78);
    put(2, 16'h0000, 8'h56); put(3, 16'h0100, 8'h99);
    run("R7", 4'd7, 16'h0600, 8'h01, 8'h40, 16'h5678, 2, 0, 3);
  endtask

  task automatic t_indirect_indexed();
    clear_mem();
    put(0, 16'h0701, 8'hFF); put(1, 16'h00FF, 8'hF0);
    put(2, 16'h0000, 8'hFF); put(3, 16'h0100, 8'h11);
    run("R8", 4'd8, 16'h0700, 8'h33, 8'h20, 16'h0010, 2, 0, 3);
  endtask

  task automatic t_indirect();
    clear_mem();
    put(0, 16'h3001, 8'hFF); put(1, 16'h3002, 8'h40);
    put(2, 16'h40FF, 8'hCD); put(3, 16'h4100, 8'hAB); put(4, 16'h4000, 8'h77);
    run("R9", 4'd6, 16'h3000, 8'h00, 8'h00, 16'hABCD, 3, 0, 4);
  endtask

  task automatic t_busy_ignore();
    int cyc = 0;
    int extra = 0;
    logic got = 1'b0;
    clear_mem();
    put(0, 16'h3001, 8'hFF); put(1, 16'h3002, 8'h40);
    put(2, 16'h40FF, 8'hCD); put(3, 16'h4100, 8'hAB);
    @(negedge clk);
    start = 1'b1; mode = 4'd6; pc = 16'h3000; idx_x = 8'h00; idx_y = 8'h00;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      if (i < 2) begin
        start = 1'b1; mode = 4'd10; pc = 16'h0000; idx_x = 8'hFF; idx_y = 8'hFF;
      end else begin
        start = 1'b0;
      end
      cyc++;
      if (valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
    check("R11", "valid seen", int'(got), 1);
    check("R11", "ea", int'(ea), 16'hABCD);
    check("R11", "len", int'(len), 3);
    check("R11", "latency", cyc, 5);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (valid || busy) extra++;
    end
    check("R11", "no extra activity", extra, 0);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_no_fetch();
    t_absolute();
    t_zero_page();
    t_relative();
    t_indexed_indirect();
    t_indirect_indexed();
    t_indirect();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule